// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block holds the current time and date as seven BCD bytes (seconds, minutes, hours, weekday, day of month, month, two-digit year for 2000 to 2099). The bytes live at byte addresses 0 to 6 in that order, and a control byte lives at address 7. A bus front end writes any byte through a single write port and reads any byte back through a combinational read port.

Time advances from a sub-second pulse input, `sub_tick`, which comes from an external prescaler. An internal phase counter divides it by `SUB_DIV`, so one second passes after `SUB_DIV` accepted pulses. A carry then ripples through minutes, hours, day, month and year. The weekday steps along with each new day.

The hour byte selects its own format. With bit 6 clear it counts 00 to 23. With bit 6 set it counts 1 to 12, and bit 5 flags PM. Rollover always follows the format that is stored at that moment. Bit 7 of the control byte halts counting. Any write to a time byte restarts the sub-second phase.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the bytes read, from address 0 to 6: 0x00, 0x00, 0x00, 0x01, 0x01, 0x01, 0x00. The control byte at address 7 reads 0x00.
- R2: A write with `wr_en` high stores `wr_data` at byte `addr` (0 to 7). `rd_data` shows the byte selected by `addr` combinationally.
- R3: Seconds advance by one after `SUB_DIV` accepted `sub_tick` pulses and not before. BCD digits carry (09 to 10). Seconds 59 wrap to 00 and step the minutes. Minutes 59 wrap to 00 and step the hour.
- R4: With hour bit 6 clear, the hour counts BCD 00 to 23. Hour 23 wraps to 00 and starts a new day.
- R5: With hour bit 6 set (bit 5 = PM, bits 4:0 = BCD 1 to 12), the hour steps as follows. 11 AM goes to 12 PM and 12 PM goes to 1 PM. 11 PM goes to 12 AM and starts a new day. 12 AM goes to 1 AM. Bit 6 is kept.
- R6: On a new day, the day of the month wraps to 01 after the month's last day: 30 for months 04, 06, 09 and 11, and 31 for the other non-February months. Month 12 wraps to 01 and steps the year. Year 99 wraps to 00.
- R7: February's last day is 29 when the BCD year is divisible by 4, and 28 otherwise.
- R8: The weekday (1 to 7) steps on each new day and wraps from 7 to 1.
- R9: While control bit 7 is set, `sub_tick` is ignored: no byte changes and the phase holds. After the bit is cleared, counting resumes from the held phase.
- R10: A write to byte 0 to 6 clears the sub-second phase, so a full `SUB_DIV` pulses are needed for the next second. A write to the control byte leaves the phase intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_tick | input | 1 | Sub-second pulse from the prescaler, one cycle wide |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Byte address, 0 to 6 time bytes, 7 control |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |

## Verification
Read data is combinational. It is due in the same cycle the address is applied, so the bench samples it one time unit after it sets the address at a falling edge. A write lands at the next rising edge. A second's advance, with its whole carry chain, lands at the rising edge that samples the `SUB_DIV`-th accepted pulse. The bench therefore reads all seven bytes only after that pulse has been removed. Stop and phase-restart cases are checked by reading after pulse counts one short of a second and then after the completing pulse.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] wday;
        logic [7:0] mday;
        logic [7:0] mon;
        logic [7:0] year;
    } cal_time_t;

    typedef enum logic [2:0] {
        ADR_SEC  = 3'd0,
        ADR_MIN  = 3'd1,
        ADR_HOUR = 3'd2,
        ADR_WDAY = 3'd3,
        ADR_MDAY = 3'd4,
        ADR_MON  = 3'd5,
        ADR_YEAR = 3'd6,
        ADR_CTRL = 3'd7
    } cal_addr_e;

    localparam int HR_FMT12_BIT = 6;
    localparam int HR_PM_BIT    = 5;
    localparam int CTRL_HALT_BIT = 7;

    localparam cal_time_t TIME_RESET = '{
        sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 8'h01,
        mday: 8'h01, mon: 8'h01, year: 8'h00
    };

    // Add one to a two-digit BCD byte.
    function automatic logic [7:0] bcd_inc(input logic [7:0] b);
        if (b[3:0] >= 4'd9)
            return {b[7:4] + 4'd1, 4'h0};
        else
            return {b[7:4], b[3:0] + 4'd1};
    endfunction

    // Divisible by 4: even tens digit needs units 0/4/8, odd tens needs 2/6.
    function automatic logic year_is_leap(input logic [7:0] y);
        if (y[4])
            return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        else
            return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    function automatic logic [7:0] month_last_day(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return year_is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_phase.sv
module cal_phase #(
    parameter int SUB_DIV = 4,
    parameter int PH_W    = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sub_tick,
    input  logic            run,
    input  logic            clear,
    output logic            sec_step,
    output logic [PH_W-1:0] phase
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SUB_DIV - 1);

    generate
        if (SUB_DIV <= 1) begin : g_direct
            assign phase    = '0;
            assign sec_step = sub_tick && run && !clear;
        end else begin : g_divided
            logic [PH_W-1:0] ph_q;
            always_ff @(posedge clk) begin
                if (rst || clear)
                    ph_q <= '0;
                else if (sub_tick && run)
                    ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
            end
            assign phase    = ph_q;
            assign sec_step = sub_tick && run && !clear && (ph_q == PH_LAST);
        end
    endgenerate
endmodule

// File: rtl/cal_hour_step.sv
module cal_hour_step
    import bcd_cal_pkg::*;
(
    input  logic [7:0] hour_in,
    output logic [7:0] hour_out,
    output logic       day_carry
);
    logic [7:0] h12;
    logic [7:0] h12_inc;

    always_comb begin
        h12       = {3'b000, hour_in[4:0]};
        h12_inc   = bcd_inc(h12);
        hour_out  = hour_in;
        day_carry = 1'b0;
        if (hour_in[HR_FMT12_BIT]) begin
            if (h12 == 8'h11) begin
                hour_out[HR_PM_BIT] = ~hour_in[HR_PM_BIT];
                hour_out[4:0]       = 5'h12;
                day_carry           = hour_in[HR_PM_BIT];
            end else if (h12 == 8'h12) begin
                hour_out[4:0] = 5'h01;
            end else begin
                hour_out[4:0] = h12_inc[4:0];
            end
        end else begin
            if (hour_in == 8'h23) begin
                hour_out  = 8'h00;
                day_carry = 1'b1;
            end else begin
                hour_out = bcd_inc(hour_in);
            end
        end
    end
endmodule

// File: rtl/cal_date_step.sv
module cal_date_step
    import bcd_cal_pkg::*;
(
    input  logic [7:0] wday_in,
    input  logic [7:0] mday_in,
    input  logic [7:0] mon_in,
    input  logic [7:0] year_in,
    output logic [7:0] wday_out,
    output logic [7:0] mday_out,
    output logic [7:0] mon_out,
    output logic [7:0] year_out
);
    logic month_end;
    logic year_end;

    always_comb begin
        month_end = (mday_in == month_last_day(mon_in, year_in));
        year_end  = month_end && (mon_in == 8'h12);

        wday_out = (wday_in >= 8'd7) ? 8'd1 : wday_in + 8'd1;
        mday_out = month_end ? 8'h01 : bcd_inc(mday_in);
        mon_out  = mon_in;
        year_out = year_in;
        if (month_end)
            mon_out = (mon_in == 8'h12) ? 8'h01 : bcd_inc(mon_in);
        if (year_end)
            year_out = (year_in == 8'h99) ? 8'h00 : bcd_inc(year_in);
    end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import bcd_cal_pkg::*;
#(
    parameter int SUB_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sub_tick,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data
);
    localparam int PH_W = (SUB_DIV > 1) ? $clog2(SUB_DIV) : 1;

    cal_time_t       time_q;
    logic [7:0]      ctrl_q;
    logic            halt;
    logic            time_wr;
    logic            sec_step;
    logic [PH_W-1:0] phase_q;

    logic            sec_wrap, min_wrap, hr_adv, day_adv;
    logic [7:0]      hour_nx;
    logic            hour_day_carry;
    logic [7:0]      wday_nx, mday_nx, mon_nx, year_nx;

    assign halt    = ctrl_q[CTRL_HALT_BIT];
    assign time_wr = wr_en && (cal_addr_e'(addr) != ADR_CTRL);

    cal_phase #(.SUB_DIV(SUB_DIV), .PH_W(PH_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .sub_tick (sub_tick),
        .run      (!halt),
        .clear    (time_wr),
        .sec_step (sec_step),
        .phase    (phase_q)
    );

    cal_hour_step u_hour (
        .hour_in   (time_q.hour),
        .hour_out  (hour_nx),
        .day_carry (hour_day_carry)
    );

    cal_date_step u_date (
        .wday_in  (time_q.wday),
        .mday_in  (time_q.mday),
        .mon_in   (time_q.mon),
        .year_in  (time_q.year),
        .wday_out (wday_nx),
        .mday_out (mday_nx),
        .mon_out  (mon_nx),
        .year_out (year_nx)
    );

    assign sec_wrap = (time_q.sec == 8'h59);
    assign min_wrap = (time_q.min == 8'h59);
    assign hr_adv   = sec_step && sec_wrap && min_wrap;
    assign day_adv  = hr_adv && hour_day_carry;

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q <= TIME_RESET;
            ctrl_q <= 8'h00;
        end else if (wr_en) begin
            case (cal_addr_e'(addr))
                ADR_SEC:  time_q.sec  <= wr_data;
                ADR_MIN:  time_q.min  <= wr_data;
                ADR_HOUR: time_q.hour <= wr_data;
                ADR_WDAY: time_q.wday <= wr_data;
                ADR_MDAY: time_q.mday <= wr_data;
                ADR_MON:  time_q.mon  <= wr_data;
                ADR_YEAR: time_q.year <= wr_data;
                default:  ctrl_q      <= wr_data;
            endcase
            if (sec_step && !time_wr) begin
                time_q.sec <= sec_wrap ? 8'h00 : bcd_inc(time_q.sec);
                if (sec_wrap)
                    time_q.min <= min_wrap ? 8'h00 : bcd_inc(time_q.min);
                if (hr_adv)
                    time_q.hour <= hour_nx;
                if (day_adv) begin
                    time_q.wday <= wday_nx;
                    time_q.mday <= mday_nx;
                    time_q.mon  <= mon_nx;
                    time_q.year <= year_nx;
                end
            end
        end else if (sec_step) begin
            time_q.sec <= sec_wrap ? 8'h00 : bcd_inc(time_q.sec);
            if (sec_wrap)
                time_q.min <= min_wrap ? 8'h00 : bcd_inc(time_q.min);
            if (hr_adv)
                time_q.hour <= hour_nx;
            if (day_adv) begin
                time_q.wday <= wday_nx;
                time_q.mday <= mday_nx;
                time_q.mon  <= mon_nx;
                time_q.year <= year_nx;
            end
        end
    end

    always_comb begin
        case (cal_addr_e'(addr))
            ADR_SEC:  rd_data = time_q.sec;
            ADR_MIN:  rd_data = time_q.min;
            ADR_HOUR: rd_data = time_q.hour;
            ADR_WDAY: rd_data = time_q.wday;
            ADR_MDAY: rd_data = time_q.mday;
            ADR_MON:  rd_data = time_q.mon;
            ADR_YEAR: rd_data = time_q.year;
            default:  rd_data = ctrl_q;
        endcase
    end
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk
    import bcd_cal_pkg::*;
#(
    parameter int PH_W = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic [2:0]      addr,
    input logic            step,
    input logic            halt,
    input logic [PH_W-1:0] phase,
    input cal_time_t       t
);
    // R9: halted and not written, nothing moves
    a_r9_halt_freezes: assert property (@(posedge clk) disable iff (rst)
        (halt && !wr_en) |=> $stable(t));

    // R10: time-byte write restarts the phase
    a_r10_phase_cleared: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr != 3'd7) |=> (phase == '0));

    // R3: seconds 59 wrap to 00
    a_r3_sec_wrap: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_en && t.sec == 8'h59) |=> (t.sec == 8'h00));

    // R4: 24-hour 23:59:59 wraps hour to 00
    a_r4_hour24_wrap: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_en && t.sec == 8'h59 && t.min == 8'h59 && t.hour == 8'h23)
        |=> (t.hour == 8'h00));

    // R5: 12-hour 11:59:59 flips the PM flag
    a_r5_pm_flip: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_en && t.sec == 8'h59 && t.min == 8'h59 &&
         t.hour[HR_FMT12_BIT] && t.hour[4:0] == 5'h11)
        |=> (t.hour[HR_PM_BIT] != $past(t.hour[HR_PM_BIT])));

    // R8: weekday 7 wraps to 1 at midnight in 24-hour form
    a_r8_wday_wrap: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_en && t.sec == 8'h59 && t.min == 8'h59 &&
         t.hour == 8'h23 && t.wday == 8'd7)
        |=> (t.wday == 8'd1));
endmodule

bind bcd_calendar bcd_calendar_chk #(.PH_W(PH_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .addr  (addr),
    .step  (sec_step),
    .halt  (halt),
    .phase (phase_q),
    .t     (time_q)
);

// File: tb/tb_bcd_calendar.sv
module tb_bcd_calendar;
    localparam int SUB_DIV = 4;

    typedef struct packed {
        logic [23:0] tag;
        logic [55:0] pre;
        logic [55:0] exp;
    } vec_t;

    // byte order in pre/exp: sec, min, hour, wday, mday, mon, year
    localparam vec_t VECS [14] = '{
        '{"R3 ", 56'h09_00_00_01_01_01_00, 56'h10_00_00_01_01_01_00},
        '{"R3 ", 56'h59_59_05_03_15_06_24, 56'h00_00_06_03_15_06_24},
        '{"R6 ", 56'h59_59_23_07_31_12_99, 56'h00_00_00_01_01_01_00},
        '{"R4 ", 56'h59_59_09_02_11_05_30, 56'h00_00_10_02_11_05_30},
        '{"R5 ", 56'h59_59_51_02_10_03_21, 56'h00_00_72_02_10_03_21},
        '{"R5 ", 56'h59_59_72_02_10_03_21, 56'h00_00_61_02_10_03_21},
        '{"R5 ", 56'h59_59_71_04_30_04_21, 56'h00_00_52_05_01_05_21},
        '{"R5 ", 56'h59_59_52_04_01_05_21, 56'h00_00_41_04_01_05_21},
        '{"R7 ", 56'h59_59_23_01_28_02_24, 56'h00_00_00_02_29_02_24},
        '{"R7 ", 56'h59_59_23_01_28_02_23, 56'h00_00_00_02_01_03_23},
        '{"R7 ", 56'h59_59_23_03_29_02_00, 56'h00_00_00_04_01_03_00},
        '{"R6 ", 56'h59_59_23_06_30_06_10, 56'h00_00_00_07_01_07_10},
        '{"R8 ", 56'h59_59_23_07_09_08_10, 56'h00_00_00_01_10_08_10},
        '{"R6 ", 56'h59_59_23_03_30_09_19, 56'h00_00_00_04_01_10_19}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sub_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2 clk = ~clk;

    bcd_calendar #(.SUB_DIV(SUB_DIV)) dut (
        .clk(clk), .rst(rst), .sub_tick(sub_tick), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sub_tick = 1'b1;
            @(negedge clk);
            sub_tick = 1'b0;
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic rd_all(output logic [55:0] v);
        logic [7:0] b;
        for (int i = 0; i < 7; i++) begin
            rd(3'(i), b);
            v[55-8*i -: 8] = b;
        end
    endtask

    task automatic load_all(input logic [55:0] v);
        for (int i = 0; i < 7; i++)
            wr(3'(i), v[55-8*i -: 8]);
    endtask

    task automatic chk(input string req, input logic [55:0] act, input logic [55:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        logic [55:0] v;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset contents
        rd_all(v);
        chk("R1", v, 56'h00_00_00_01_01_01_00);
        rd(3'd7, b);
        chk("R1", {48'h0, b}, {48'h0, 8'h00});

        // R2: control byte write and read back
        wr(3'd7, 8'h35);
        rd(3'd7, b);
        chk("R2", {48'h0, b}, {48'h0, 8'h35});
        wr(3'd7, 8'h00);

        // Vector table: load, one full second, read back
        for (int k = 0; k < 14; k++) begin
            load_all(VECS[k].pre);
            rd_all(v);
            chk("R2", v, VECS[k].pre);
            ticks(SUB_DIV);
            rd_all(v);
            chk(string'(VECS[k].tag), v, VECS[k].exp);
        end

        // R3: one pulse short of a second leaves seconds unchanged
        load_all(56'h20_00_00_01_01_01_00);
        ticks(SUB_DIV - 1);
        rd(3'd0, b);
        chk("R3", {48'h0, b}, {48'h0, 8'h20});
        ticks(1);
        rd(3'd0, b);
        chk("R3", {48'h0, b}, {48'h0, 8'h21});

        // R9: halted, pulses ignored
        wr(3'd7, 8'h80);
        ticks(2 * SUB_DIV);
        rd_all(v);
        chk("R9", v, 56'h21_00_00_01_01_01_00);
        wr(3'd7, 8'h00);
        ticks(SUB_DIV);
        rd(3'd0, b);
        chk("R9", {48'h0, b}, {48'h0, 8'h22});

        // R9: phase held across the halt
        ticks(SUB_DIV - 1);
        wr(3'd7, 8'h80);
        ticks(3);
        wr(3'd7, 8'h00);
        ticks(1);
        rd(3'd0, b);
        chk("R9", {48'h0, b}, {48'h0, 8'h23});

        // R10: time write restarts the phase
        ticks(SUB_DIV - 1);
        wr(3'd0, 8'h30);
        ticks(SUB_DIV - 1);
        rd(3'd0, b);
        chk("R10", {48'h0, b}, {48'h0, 8'h30});
        ticks(1);
        rd(3'd0, b);
        chk("R10", {48'h0, b}, {48'h0, 8'h31});

        // R10: control write keeps the phase
        ticks(SUB_DIV - 1);
        wr(3'd7, 8'h00);
        ticks(1);
        rd(3'd0, b);
        chk("R10", {48'h0, b}, {48'h0, 8'h32});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule